// File: doc/BRIEF.md
# Synchronous Clock Stop Gating Controller

This block sits behind a clock synthesizer's divider network and decides, cycle by cycle, which divided clocks reach the output buffers. It produces a set of differential processor clock pairs, one differential serial-reference pair, a group of stoppable PCI clocks and a group of free-running PCI clocks. Each clock is made from a phase signal divided down from the fast reference clock. The divided phases always run. Only the gate in front of each output opens or closes.

Three requests close the gates. A processor stop pin closes the processor pairs. A PCI stop, raised either by its pin or by a software run bit written to 0, closes the PCI clocks, any free-running PCI clock configured as stoppable, and the serial-reference pair when that pair is configured to follow the PCI stop. A power-down pin closes every gate. The pins are asynchronous and are synchronized first. A gate changes state only while its phase is low, so no output ever shows a shortened high or low pulse.

Each differential pair has three configuration bits: an output enable, a stop drive mode and a power-down drive mode. Together these decide whether a closed pair is held at true low / complement high or is released to high impedance.

Top module: `ckstop_ctrl`

## Requirements
- R1: While reset is asserted, every true clock output and every PCI clock is low and every complement output is high. Each pair's enable flag then equals its enable bit ANDed with the inverse of its stop drive-mode bit.
- R2: With no request active, every processor and serial-reference output toggles with high and low phases of exactly CPU_HALF and SRC_HALF reference cycles. Every PCI clock has phases of 2*V66_HALF cycles, which is half the 66 MHz rate.
- R3: Whenever a pair's output enable flag is 1, its complement output is the logical inverse of its true output.
- R4: A PCI stop request (pin low, or software run bit 0) holds all PCI clocks low. It also holds low each free-running PCI clock whose stoppable bit is 1, and the serial-reference pair when its follow bit is 1. This takes effect within 2 + 2*HALF + 1 reference cycles.
- R5: Every high pulse on any output lasts exactly its half period, and every low pulse lasts at least its half period. This holds across stops, resumes and power-down.
- R6: A free-running PCI clock with stoppable bit 0 keeps running during a PCI stop. The serial-reference pair with follow bit 0 also keeps running during a PCI stop. The follow bit is meant to come out of reset at 0.
- R7: A processor stop request closes only the processor pairs. PCI clocks and the serial-reference pair keep running.
- R8: A closed pair that is not in power-down is driven (true 0, complement 1, enable flag 1) when its stop drive-mode bit is 0. It is released (enable flag 0) when that bit is 1.
- R9: Power-down closes every output. For each pair the power-down drive-mode bit (1 = high impedance) decides the enable flag in place of the stop drive-mode bit. When power-down and a PCI stop arrive in the same cycle, power-down decides the drive mode.
- R10: A pair whose enable bit is 0 has its enable flag at 0 in every state. The enable bits are meant to come out of reset at 1.
- R11: Once every request affecting an output is withdrawn, that output restarts within 2 + 2*HALF + 1 cycles, and its first high pulse has full width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_stop_n | input | 1 | Processor stop pin, active low, asynchronous |
| pci_stop_n | input | 1 | PCI stop pin, active low, asynchronous |
| pwr_dn_n | input | 1 | Power-down pin, active low, asynchronous |
| sw_pci_run | input | 1 | Software PCI run bit; 0 requests a PCI stop |
| cpu_en | input | N_CPU | Per-pair output enable bits |
| cpu_stop_tri | input | N_CPU | Per-pair stop drive mode (1 = high impedance) |
| cpu_pd_tri | input | N_CPU | Per-pair power-down drive mode (1 = high impedance) |
| src_en | input | 1 | Serial-reference pair output enable |
| src_on_pci_stop | input | 1 | 1 = serial-reference pair follows the PCI stop |
| src_stop_tri | input | 1 | Serial-reference stop drive mode |
| src_pd_tri | input | 1 | Serial-reference power-down drive mode |
| pcif_on_pci_stop | input | N_PCIF | Per-clock stoppable bits for the free-running PCI clocks |
| cpu_t | output | N_CPU | Processor pair true outputs |
| cpu_c | output | N_CPU | Processor pair complement outputs |
| cpu_oe | output | N_CPU | Processor pair output enable flags |
| src_t | output | 1 | Serial-reference true output |
| src_c | output | 1 | Serial-reference complement output |
| src_oe | output | 1 | Serial-reference output enable flag |
| pci_clk | output | N_PCI | Stoppable PCI clocks |
| pcif_clk | output | N_PCIF | Free-running PCI clocks |

## Verification
Two functions can fall in the same cycle: the power-down request and the PCI stop request. The bench lowers both pins at the same falling clock edge while the serial-reference pair follows the PCI stop and has opposite stop and power-down drive modes. It then expects the pair to stay driven, because power-down decides the mode. When power-down alone is released, the enable flag must drop under the stop mode while the clock stays low. A pulse-width monitor runs across the whole sequence and flags any shortened pulse that overlapping gate changes might produce.

// File: rtl/ckstop_pkg.sv
package ckstop_pkg;

  // Closed-gate drive decision for a differential pair.
  function automatic logic pair_drive(input logic en, input logic gate_open,
                                      input logic pd_now, input logic stop_tri,
                                      input logic pd_tri);
    logic hiz;
    hiz = pd_now ? pd_tri : stop_tri;
    return en & (gate_open | ~hiz);
  endfunction

  // A lane keeps running unless it is stoppable and a stop is requested.
  function automatic logic lane_run(input logic stop_req, input logic stoppable);
    return ~(stop_req & stoppable);
  endfunction

  // Width of a half-period counter.
  function automatic int half_cnt_w(input int half);
    return (half > 1) ? $clog2(half) : 1;
  endfunction

endpackage

// File: rtl/ckstop_sync.sv
module ckstop_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '1;
      sync_q <= '1;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
    end
  end

  assign sync_o = sync_q;
endmodule

// File: rtl/ckstop_phase.sv
module ckstop_phase
  import ckstop_pkg::*;
#(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic phase_o
);
  localparam int CW = half_cnt_w(HALF);
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt_q;
  logic          phase_q;
  logic          wrap;

  assign wrap = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (wrap) begin
      cnt_q   <= '0;
      phase_q <= ~phase_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/ckstop_lane.sv
module ckstop_lane (
  input  logic clk,
  input  logic rst_n,
  input  logic phase,
  input  logic run_req,
  input  logic pd_req,
  output logic clk_o,
  output logic gate_o
);
  logic gate_q;

  // The gate may only move while the phase is low, so the output never
  // carries a partial pulse.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      gate_q <= 1'b0;
    else if (!phase) gate_q <= run_req & ~pd_req;
  end

  assign clk_o  = phase & gate_q;
  assign gate_o = gate_q;
endmodule

// File: rtl/ckstop_ctrl.sv
module ckstop_ctrl
  import ckstop_pkg::*;
#(
  parameter int N_CPU    = 3,
  parameter int N_PCI    = 7,
  parameter int N_PCIF   = 3,
  parameter int CPU_HALF = 2,
  parameter int SRC_HALF = 2,
  parameter int V66_HALF = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_stop_n,
  input  logic              pci_stop_n,
  input  logic              pwr_dn_n,
  input  logic              sw_pci_run,
  input  logic [N_CPU-1:0]  cpu_en,
  input  logic [N_CPU-1:0]  cpu_stop_tri,
  input  logic [N_CPU-1:0]  cpu_pd_tri,
  input  logic              src_en,
  input  logic              src_on_pci_stop,
  input  logic              src_stop_tri,
  input  logic              src_pd_tri,
  input  logic [N_PCIF-1:0] pcif_on_pci_stop,
  output logic [N_CPU-1:0]  cpu_t,
  output logic [N_CPU-1:0]  cpu_c,
  output logic [N_CPU-1:0]  cpu_oe,
  output logic              src_t,
  output logic              src_c,
  output logic              src_oe,
  output logic [N_PCI-1:0]  pci_clk,
  output logic [N_PCIF-1:0] pcif_clk
);
  localparam int PCI_HALF = 2 * V66_HALF;
  localparam int N_PIN    = 3;

  // Named internal events, brought out for the checker.
  logic [N_PIN-1:0]  pin_sync;
  logic              cpu_stop_req;
  logic              pci_stop_req;
  logic              pd_req;
  logic              cpu_phase;
  logic              src_phase;
  logic              pci_phase;
  logic [N_CPU-1:0]  cpu_gate;
  logic              src_gate;
  logic [N_PCI-1:0]  pci_gate;
  logic [N_PCIF-1:0] pcif_gate;

  ckstop_sync #(.W(N_PIN)) sync_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i({pwr_dn_n, pci_stop_n, cpu_stop_n}),
    .sync_o (pin_sync)
  );

  assign cpu_stop_req = ~pin_sync[0];
  assign pci_stop_req = ~pin_sync[1] | ~sw_pci_run;
  assign pd_req       = ~pin_sync[2];

  ckstop_phase #(.HALF(CPU_HALF)) cpu_ph_i (.clk(clk), .rst_n(rst_n), .phase_o(cpu_phase));
  ckstop_phase #(.HALF(SRC_HALF)) src_ph_i (.clk(clk), .rst_n(rst_n), .phase_o(src_phase));
  ckstop_phase #(.HALF(PCI_HALF)) pci_ph_i (.clk(clk), .rst_n(rst_n), .phase_o(pci_phase));

  for (genvar i = 0; i < N_CPU; i++) begin : g_cpu
    ckstop_lane lane_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .phase  (cpu_phase),
      .run_req(~cpu_stop_req),
      .pd_req (pd_req),
      .clk_o  (cpu_t[i]),
      .gate_o (cpu_gate[i])
    );
    assign cpu_c[i]  = ~cpu_t[i];
    assign cpu_oe[i] = pair_drive(cpu_en[i], cpu_gate[i], pd_req,
                                  cpu_stop_tri[i], cpu_pd_tri[i]);
  end

  ckstop_lane src_lane_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .phase  (src_phase),
    .run_req(lane_run(pci_stop_req, src_on_pci_stop)),
    .pd_req (pd_req),
    .clk_o  (src_t),
    .gate_o (src_gate)
  );
  assign src_c  = ~src_t;
  assign src_oe = pair_drive(src_en, src_gate, pd_req, src_stop_tri, src_pd_tri);

  for (genvar k = 0; k < N_PCI; k++) begin : g_pci
    ckstop_lane lane_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .phase  (pci_phase),
      .run_req(~pci_stop_req),
      .pd_req (pd_req),
      .clk_o  (pci_clk[k]),
      .gate_o (pci_gate[k])
    );
  end

  for (genvar j = 0; j < N_PCIF; j++) begin : g_pcif
    ckstop_lane lane_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .phase  (pci_phase),
      .run_req(lane_run(pci_stop_req, pcif_on_pci_stop[j])),
      .pd_req (pd_req),
      .clk_o  (pcif_clk[j]),
      .gate_o (pcif_gate[j])
    );
  end
endmodule

// File: rtl/ckstop_ctrl_chk.sv
module ckstop_ctrl_chk #(
  parameter int N_CPU  = 3,
  parameter int N_PCI  = 7,
  parameter int N_PCIF = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_CPU-1:0]  cpu_t,
  input logic [N_CPU-1:0]  cpu_c,
  input logic [N_CPU-1:0]  cpu_oe,
  input logic [N_CPU-1:0]  cpu_en,
  input logic              cpu_phase,
  input logic              src_phase,
  input logic              pci_phase,
  input logic              src_gate,
  input logic              src_oe,
  input logic              src_en,
  input logic [N_PCI-1:0]  pci_clk,
  input logic [N_PCIF-1:0] pcif_clk,
  input logic              pd_req
);
  p_comp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_oe & ~(cpu_t ^ cpu_c)) == '0);

  p_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((cpu_oe & ~cpu_en) == '0) && !(src_oe && !src_en));

  p_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|(cpu_t & ~$past(cpu_t))) |-> $rose(cpu_phase));

  p_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|(~cpu_t & $past(cpu_t))) |-> $fell(cpu_phase));

  p_pci_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|({pcif_clk, pci_clk} & ~$past({pcif_clk, pci_clk}))) |-> $rose(pci_phase));

  p_gate_move_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (src_gate != $past(src_gate)) |-> !$past(src_phase));

  p_pd_close_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_req && !src_phase) |=> !src_gate);
endmodule

bind ckstop_ctrl ckstop_ctrl_chk #(.N_CPU(N_CPU), .N_PCI(N_PCI), .N_PCIF(N_PCIF)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .cpu_t    (cpu_t),
  .cpu_c    (cpu_c),
  .cpu_oe   (cpu_oe),
  .cpu_en   (cpu_en),
  .cpu_phase(cpu_phase),
  .src_phase(src_phase),
  .pci_phase(pci_phase),
  .src_gate (src_gate),
  .src_oe   (src_oe),
  .src_en   (src_en),
  .pci_clk  (pci_clk),
  .pcif_clk (pcif_clk),
  .pd_req   (pd_req)
);

// File: tb/ckstop_ctrl_tb.sv
`timescale 1ns/1ps
module ckstop_ctrl_tb_top;
  localparam int N_CPU = 3, N_PCI = 7, N_PCIF = 3;
  localparam int CPU_H = 2, SRC_H = 2, PCI_H = 2 * 3;
  localparam int SETTLE = 24;
  localparam int WIN = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_stop_n = 1'b1, pci_stop_n = 1'b1, pwr_dn_n = 1'b1, sw_pci_run = 1'b1;
  logic [N_CPU-1:0] cpu_en = '1, cpu_stop_tri = '0, cpu_pd_tri = '0;
  logic src_en = 1'b1, src_on_pci_stop = 1'b0, src_stop_tri = 1'b0, src_pd_tri = 1'b0;
  logic [N_PCIF-1:0] pcif_on_pci_stop = '0;
  logic [N_CPU-1:0] cpu_t, cpu_c, cpu_oe;
  logic src_t, src_c, src_oe;
  logic [N_PCI-1:0] pci_clk;
  logic [N_PCIF-1:0] pcif_clk;

  int n_chk = 0;
  int n_fail = 0;
  bit mon_on = 1'b0;

  always #4 clk = ~clk;

  ckstop_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n),
    .pwr_dn_n(pwr_dn_n), .sw_pci_run(sw_pci_run), .cpu_en(cpu_en),
    .cpu_stop_tri(cpu_stop_tri), .cpu_pd_tri(cpu_pd_tri), .src_en(src_en),
    .src_on_pci_stop(src_on_pci_stop), .src_stop_tri(src_stop_tri),
    .src_pd_tri(src_pd_tri), .pcif_on_pci_stop(pcif_on_pci_stop),
    .cpu_t(cpu_t), .cpu_c(cpu_c), .cpu_oe(cpu_oe), .src_t(src_t), .src_c(src_c),
    .src_oe(src_oe), .pci_clk(pci_clk), .pcif_clk(pcif_clk)
  );

  // Monitored lanes: 0..2 cpu, 3 src, 4 pci0, 5 pci6, 6 pcif0, 7 pcif1
  logic [7:0] mon;
  assign mon = {pcif_clk[1], pcif_clk[0], pci_clk[6], pci_clk[0], src_t, cpu_t};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int half_of(input int k);
    return (k < 3) ? CPU_H : (k == 3) ? SRC_H : PCI_H;
  endfunction

  // Pulse-width monitor (R2, R5) and complement check (R3).
  int run_len [8];
  logic [7:0] last_v;
  always @(negedge clk) begin
    if (mon_on) begin
      for (int k = 0; k < 8; k++) begin
        if (mon[k] != last_v[k]) begin
          if (last_v[k]) chk(run_len[k] == half_of(k), "R5 high width", run_len[k], half_of(k));
          else           chk(run_len[k] >= half_of(k), "R5 low width", run_len[k], half_of(k));
          run_len[k] = 1;
        end else begin
          run_len[k]++;
        end
      end
      last_v = mon;
      for (int i = 0; i < N_CPU; i++)
        if (cpu_oe[i]) chk(cpu_c[i] == ~cpu_t[i], "R3 complement", int'(cpu_c[i]), int'(~cpu_t[i]));
    end
  end

  task automatic settle();
    repeat (SETTLE) @(negedge clk);
  endtask

  task automatic watch(input logic [7:0] exp_mask, input string req);
    logic [7:0] saw = '0;
    repeat (WIN) @(negedge clk) saw |= mon;
    chk(saw == exp_mask, req, int'(saw), int'(exp_mask));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    // R1: reset state
    chk(cpu_t == 3'b000 && src_t == 1'b0, "R1 true low", int'({src_t, cpu_t}), 0);
    chk(cpu_c == 3'b111 && src_c == 1'b1, "R1 comp high", int'({src_c, cpu_c}), 15);
    chk(pci_clk == '0 && pcif_clk == '0, "R1 pci low", int'({pcif_clk, pci_clk}), 0);
    chk(cpu_oe == 3'b111, "R1 enable flag", int'(cpu_oe), 7);
    rst_n = 1'b1;
    for (int k = 0; k < 8; k++) run_len[k] = 0;
    last_v = '0;
    mon_on = 1'b1;
    settle();
    watch(8'hFF, "R2 all running");

    // R4/R6: PCI stop by pin, src free, PCIF not stoppable
    pci_stop_n = 1'b0; settle();
    watch(8'hCF, "R4 R6 pin stop");
    chk(pci_clk == '0, "R4 pci held low", int'(pci_clk), 0);

    // R4/R8: src follows stop, pcif0 stoppable
    src_on_pci_stop = 1'b1; pcif_on_pci_stop = 3'b101; settle();
    watch(8'h87, "R4 src and pcif0 stop");
    chk(src_t == 0 && src_c == 1 && src_oe == 1, "R8 driven stop", int'({src_t, src_c, src_oe}), 3);
    src_stop_tri = 1'b1; repeat (2) @(negedge clk);
    chk(src_oe == 1'b0, "R8 tri stop", int'(src_oe), 0);

    // R4: software stop keeps it stopped after the pin releases
    sw_pci_run = 1'b0; pci_stop_n = 1'b1; settle();
    watch(8'h87, "R4 sw stop");
    sw_pci_run = 1'b1; settle();
    watch(8'hFF, "R11 resume pci");
    chk(src_oe == 1'b1, "R11 src enabled", int'(src_oe), 1);

    // R7/R8: processor stop, pair 1 released
    cpu_stop_tri = 3'b010; cpu_stop_n = 1'b0; settle();
    watch(8'hF8, "R7 cpu stop only");
    chk(cpu_oe == 3'b101, "R8 cpu stop modes", int'(cpu_oe), 5);
    chk(cpu_t == 3'b000 && cpu_c == 3'b111, "R8 cpu held", int'({cpu_c, cpu_t}), 56);
    cpu_en[2] = 1'b0; repeat (2) @(negedge clk);
    chk(cpu_oe == 3'b001, "R10 disabled pair", int'(cpu_oe), 1);
    cpu_en[2] = 1'b1; cpu_stop_n = 1'b1; settle();
    watch(8'hFF, "R11 resume cpu");

    // R9: power-down overrides stop mode, closes non-stoppable too
    cpu_stop_tri = 3'b111; cpu_pd_tri = 3'b100; src_stop_tri = 1'b1; src_pd_tri = 1'b0;
    pwr_dn_n = 1'b0; settle();
    watch(8'h00, "R9 all closed");
    chk(cpu_oe == 3'b011, "R9 cpu pd modes", int'(cpu_oe), 3);
    chk(src_oe == 1'b1, "R9 src pd mode", int'(src_oe), 1);
    pwr_dn_n = 1'b1; settle();
    watch(8'hFF, "R11 resume pd");

    // R9: power-down and PCI stop in the same cycle
    pcif_on_pci_stop = '0;
    @(negedge clk); pwr_dn_n = 1'b0; pci_stop_n = 1'b0;
    settle();
    chk(src_oe == 1'b1 && src_t == 1'b0, "R9 pd wins", int'({src_oe, src_t}), 2);
    pwr_dn_n = 1'b1; settle();
    chk(src_oe == 1'b0 && src_t == 1'b0, "R8 stop after pd", int'({src_oe, src_t}), 0);
    watch(8'hC7, "R4 stop after pd");
    pci_stop_n = 1'b1; settle();
    watch(8'hFF, "R11 final resume");

    // R8/R9/R10 sweep of pair 0 drive bits
    cpu_stop_n = 1'b0; settle();
    for (int m = 0; m < 8; m++) begin
      cpu_en[0] = m[0]; cpu_stop_tri[0] = m[1]; cpu_pd_tri[0] = m[2];
      repeat (2) @(negedge clk);
      chk(cpu_oe[0] == (m[0] & ~m[1]), "R8 sweep stop", int'(cpu_oe[0]), int'(m[0] & ~m[1]));
    end
    cpu_stop_n = 1'b1; pwr_dn_n = 1'b0; settle();
    for (int m = 0; m < 8; m++) begin
      cpu_en[0] = m[0]; cpu_stop_tri[0] = m[1]; cpu_pd_tri[0] = m[2];
      repeat (2) @(negedge clk);
      chk(cpu_oe[0] == (m[0] & ~m[2]), "R9 sweep pd", int'(cpu_oe[0]), int'(m[0] & ~m[2]));
    end
    pwr_dn_n = 1'b1; cpu_en = '1; settle();
    watch(8'hFF, "R11 after sweep");

    mon_on = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule